// File: doc/BRIEF.md
# Supply-Drop Monitor Interrupt Controller

This block is the digital half of a supply-voltage-drop detector inside a microcontroller. An analog comparator, outside the block, reports whether the supply is at or above a threshold. The block resynchronises that level and samples it on a tick taken from the CPU clock, with a selectable divide ratio. It then filters the samples, so that the level changes only after two consecutive samples agree. It keeps a monitor flag that tracks the filtered level and a sticky crossing flag that records any change of that level.

When the crossing flag rises and the interrupt enable is set, the block issues a one-cycle interrupt pulse. A separate wake control bit lets the same event raise a one-cycle wake request while the device is in stop mode. Once that wake has been used, the bit is spent and must be re-armed by writing 0 and then 1. After the detector is switched on, results are ignored until a settle delay and one sampling tick have passed.

Software reaches three registers through a simple address/data port. Writes to the enable and control registers need an external write-protect release. A power-on or hardware reset initialises everything. A warm reset (software, watchdog or oscillation-stop) clears only the control register, so the detector enable and the monitor level survive it.

Top module: `vdrop_mon_top`

## Requirements
- R1: Control register (address 2) bits [5:4] pick the sampling tick: 00 every 8 CPU cycles, 01 every 16, 10 every 32, 11 every 64; a level held for 40 cycles is filtered out at 11 but accepted at 00 and 01.
- R2: While the detector enable (address 1, bit 0) is 0, the monitor flag (address 0, bit 0) reads 1 and the crossing flag (address 2, bit 2) reads 0.
- R3: The crossing flag and the watchdog-overflow flag (address 2, bit 3, set by a `wdt_ovf` pulse) clear only when software writes 0 to them; writing 1 leaves them unchanged.
- R4: Writes to addresses 1 and 2 have no effect while `wr_prot_en` is 0.
- R5: `por_n` low clears all state; `warm_rst` clears the control register to 0 but keeps the detector enable and the monitor flag.
- R6: Wake control (address 2, bit 1): after one wake request the bit is spent; writing 1 again does not re-arm it, a write of 0 followed by a write of 1 does.
- R7: After the detector enable goes from 0 to 1, comparator results are ignored until SETTLE_CYC cycles and then one sampling tick have passed; the first accepted sample loads the level without setting the crossing flag.
- R8: Address 0 ignores writes, address 3 reads 0, and every unassigned bit reads 0 (address 0 and 1 bits [7:1], address 2 bits [7:6]).
- R9: The filtered level changes only when two consecutive samples agree and differ from it; a pulse shorter than one sampling period has no effect.
- R10: `irq_pulse` is high for one cycle when the crossing flag goes from 0 to 1 with the interrupt enable (address 2, bit 0) set, and never otherwise.
- R11: `wake_req` pulses for a crossing only while `stop_mode` is 1 and the wake control is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on / hardware reset, active low, asynchronous |
| warm_rst | input | 1 | Software, watchdog or oscillation-stop reset, synchronous |
| cmp_above | input | 1 | Raw comparator: 1 when the supply is at or above threshold |
| stop_mode | input | 1 | Device is in stop mode |
| wdt_ovf | input | 1 | Watchdog overflow event |
| wr_prot_en | input | 1 | Write-protect release for addresses 1 and 2 |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| wake_req | output | 1 | One-cycle stop-mode wake request |

## Verification
The bench goes after the sticky flag semantics. A design that cleared on a write of 1 would lose the crossing flag, and one that re-armed the wake on a second write of 1 would issue a second wake. It checks the settle window by holding the comparator low across enable: a design that took samples early would show the monitor flag at 0 during the delay or set the crossing flag on the first load. The filter is tested against the selected rate with a 40-cycle pulse, which a wrong divider decode would accept at the slowest rate or reject at the faster ones. Random level sequences with short glitches confirm that exactly one interrupt is issued per real change, and that none is issued while the flag is already set or the enable is cleared.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
   typedef logic [1:0] addr_t;

   localparam addr_t A_MON = 2'd0;
   localparam addr_t A_EN  = 2'd1;
   localparam addr_t A_INT = 2'd2;

   localparam int B_MON = 0;
   localparam int B_DET = 0;
   localparam int B_IE  = 0;
   localparam int B_ARM = 1;
   localparam int B_CRS = 2;
   localparam int B_WDT = 3;
   localparam int B_SEL = 4;
endpackage

// File: rtl/vdm_sync.sv
module vdm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic d,
   output logic q
);
   initial begin
      assert (STAGES >= 0) else $error("STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               ff_q <= '1;
            end else begin
               ff_q[0] <= d;
               for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
            end
         end
         assign q = ff_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/vdm_sampler.sv
module vdm_sampler #(
   parameter int MIN_DIV_LOG = 3,
   parameter int SEL_W       = 2,
   parameter int SETTLE_CYC  = 100
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             det_en,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic             cmp_s,
   output logic             filt_level,
   output logic             cross_evt
);
   localparam int MAX_LOG = MIN_DIV_LOG + (1 << SEL_W) - 1;
   localparam int CNT_W   = $clog2(SETTLE_CYC + 1);

   initial begin
      assert (MIN_DIV_LOG >= 1) else $error("MIN_DIV_LOG must be at least 1");
      assert (SEL_W >= 1 && SEL_W <= 3) else $error("SEL_W out of range");
      assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");
   end

   logic [MAX_LOG-1:0] pre_q;
   logic [MAX_LOG-1:0] ones;
   logic [MAX_LOG-1:0] mask;
   logic               tick;
   logic               en_q;
   logic               en_rise;
   logic [CNT_W-1:0]   settle_q;
   logic               settled;
   logic               ready_q;
   logic               smp_q;
   logic               filt_q;

   assign ones    = '1;
   assign mask    = ones >> (MAX_LOG - MIN_DIV_LOG - int'(rate_sel));
   assign tick    = ((pre_q & mask) == mask);
   assign en_rise = det_en & ~en_q;
   assign settled = (settle_q == '0) & ~en_rise;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pre_q    <= '0;
         en_q     <= 1'b0;
         settle_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
         en_q  <= det_en;
         if (en_rise)              settle_q <= CNT_W'(SETTLE_CYC);
         else if (settle_q != '0)  settle_q <= settle_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ready_q <= 1'b0;
         smp_q   <= 1'b1;
         filt_q  <= 1'b1;
      end else if (!det_en) begin
         ready_q <= 1'b0;
         smp_q   <= 1'b1;
         filt_q  <= 1'b1;
      end else if (tick && settled) begin
         smp_q <= cmp_s;
         if (!ready_q) begin
            filt_q  <= cmp_s;
            ready_q <= 1'b1;
         end else if (cmp_s == smp_q && cmp_s != filt_q) begin
            filt_q <= cmp_s;
         end
      end
   end

   assign cross_evt  = det_en & ready_q & tick & settled & (cmp_s == smp_q) & (cmp_s != filt_q);
   assign filt_level = filt_q;

   // R7
   settle_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
      (settle_q != '0) |-> !ready_q);
   // R9
   filt_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (det_en && !tick) |=> $stable(filt_q));
endmodule

// File: rtl/vdm_regs.sv
module vdm_regs
   import vdm_pkg::*;
#(
   parameter int SEL_W = 2,
   parameter int FW    = 6
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             warm_rst,
   input  logic             wr,
   input  addr_t            addr,
   input  logic [FW-1:0]    wdata,
   input  logic             prot_ok,
   input  logic             cross_evt,
   input  logic             wdt_ovf,
   input  logic             stop_mode,
   output logic             det_en,
   output logic [SEL_W-1:0] rate_sel,
   output logic             irq_en,
   output logic             wake_arm,
   output logic             cross_flag,
   output logic             wdt_flag,
   output logic             irq_pulse,
   output logic             wake_req
);
   initial begin
      assert (FW == B_SEL + SEL_W) else $error("FW must cover the rate field");
   end

   logic wr_en_reg;
   logic wr_int_reg;
   logic spent_q;
   logic wake_fire;

   assign wr_en_reg  = wr & prot_ok & (addr == A_EN);
   assign wr_int_reg = wr & prot_ok & (addr == A_INT);
   assign wake_fire  = cross_evt & stop_mode & wake_arm & ~spent_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         det_en <= 1'b0;
      else if (wr_en_reg) det_en <= wdata[B_DET];
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         irq_en     <= 1'b0;
         wake_arm   <= 1'b0;
         spent_q    <= 1'b0;
         rate_sel   <= '0;
         cross_flag <= 1'b0;
         wdt_flag   <= 1'b0;
         irq_pulse  <= 1'b0;
         wake_req   <= 1'b0;
      end else if (warm_rst) begin
         irq_en     <= 1'b0;
         wake_arm   <= 1'b0;
         spent_q    <= 1'b0;
         rate_sel   <= '0;
         cross_flag <= 1'b0;
         wdt_flag   <= 1'b0;
         irq_pulse  <= 1'b0;
         wake_req   <= 1'b0;
      end else begin
         if (wr_int_reg) begin
            irq_en   <= wdata[B_IE];
            wake_arm <= wdata[B_ARM];
            rate_sel <= wdata[B_SEL +: SEL_W];
            if (!wdata[B_ARM]) spent_q <= 1'b0;
         end
         if (wake_fire) spent_q <= 1'b1;

         if (!det_en)                           cross_flag <= 1'b0;
         else if (cross_evt)                    cross_flag <= 1'b1;
         else if (wr_int_reg && !wdata[B_CRS])  cross_flag <= 1'b0;

         if (wdt_ovf)                           wdt_flag <= 1'b1;
         else if (wr_int_reg && !wdata[B_WDT])  wdt_flag <= 1'b0;

         irq_pulse <= cross_evt & ~cross_flag & irq_en;
         wake_req  <= wake_fire;
      end
   end

   // R2
   off_flag_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      !det_en |=> !cross_flag);
   // R3
   cross_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (cross_flag && det_en && !warm_rst && !(wr_int_reg && !wdata[B_CRS])) |=> cross_flag);
   // R4
   en_protect_chk: assert property (@(posedge clk) disable iff (!por_n)
      !(wr && prot_ok) |=> $stable(det_en));
   // R5
   en_warm_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (warm_rst && !wr) |=> ($stable(det_en) && !irq_en && !cross_flag));
   // R10
   irq_with_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
      irq_pulse |-> cross_flag);
   // R10
   irq_single_chk: assert property (@(posedge clk) disable iff (!por_n)
      irq_pulse |=> !irq_pulse);
   // R6
   wake_spends_chk: assert property (@(posedge clk) disable iff (!por_n)
      wake_req |-> spent_q);
   // R11
   wake_in_stop_chk: assert property (@(posedge clk) disable iff (!por_n)
      wake_req |-> $past(stop_mode));
endmodule

// File: rtl/vdrop_mon_top.sv
module vdrop_mon_top
   import vdm_pkg::*;
#(
   parameter int DW          = 8,
   parameter int MIN_DIV_LOG = 3,
   parameter int SEL_W       = 2,
   parameter int SETTLE_CYC  = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          warm_rst,
   input  logic          cmp_above,
   input  logic          stop_mode,
   input  logic          wdt_ovf,
   input  logic          wr_prot_en,
   input  logic [1:0]    reg_addr,
   input  logic          reg_wr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          irq_pulse,
   output logic          wake_req
);
   localparam int FW = B_SEL + SEL_W;

   initial begin
      assert (DW > FW) else $error("DW must exceed the field width");
   end

   logic             cmp_s;
   logic             det_en;
   logic [SEL_W-1:0] rate_sel;
   logic             irq_en;
   logic             wake_arm;
   logic             cross_flag;
   logic             wdt_flag;
   logic             filt_level;
   logic             cross_evt;
   logic             unused_wr_hi;

   assign unused_wr_hi = ^reg_wdata[DW-1:FW];

   vdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .d(cmp_above), .q(cmp_s)
   );

   vdm_sampler #(
      .MIN_DIV_LOG(MIN_DIV_LOG), .SEL_W(SEL_W), .SETTLE_CYC(SETTLE_CYC)
   ) u_samp (
      .clk(clk), .por_n(por_n), .det_en(det_en), .rate_sel(rate_sel),
      .cmp_s(cmp_s), .filt_level(filt_level), .cross_evt(cross_evt)
   );

   vdm_regs #(.SEL_W(SEL_W), .FW(FW)) u_regs (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .wr(reg_wr),
      .addr(reg_addr), .wdata(reg_wdata[FW-1:0]), .prot_ok(wr_prot_en),
      .cross_evt(cross_evt), .wdt_ovf(wdt_ovf), .stop_mode(stop_mode),
      .det_en(det_en), .rate_sel(rate_sel), .irq_en(irq_en),
      .wake_arm(wake_arm), .cross_flag(cross_flag), .wdt_flag(wdt_flag),
      .irq_pulse(irq_pulse), .wake_req(wake_req)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_MON: reg_rdata[B_MON] = det_en ? filt_level : 1'b1;
         A_EN:  reg_rdata[B_DET] = det_en;
         A_INT: begin
            reg_rdata[B_IE]            = irq_en;
            reg_rdata[B_ARM]           = wake_arm;
            reg_rdata[B_CRS]           = cross_flag;
            reg_rdata[B_WDT]           = wdt_flag;
            reg_rdata[B_SEL +: SEL_W]  = rate_sel;
         end
         default: reg_rdata = '0;
      endcase
   end

   // R8
   hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      reg_rdata[DW-1:FW] == '0);
   // R8
   narrow_regs_chk: assert property (@(posedge clk) disable iff (!por_n)
      (reg_addr != A_INT) |-> (reg_rdata[DW-1:1] == '0));
   // R2
   off_mon_high_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!det_en && reg_addr == A_MON) |-> reg_rdata[B_MON]);
endmodule

// File: tb/tb_vdrop_mon_top.sv
module tb_vdrop_mon_top;
   localparam int SETTLE = 100;

   logic       clk = 1'b0;
   logic       por_n, warm_rst, cmp_above, stop_mode, wdt_ovf, wr_prot_en, reg_wr;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       irq_pulse, wake_req;

   int n_chk = 0, n_bad = 0, irq_cnt = 0, wake_cnt = 0;
   int exp_irq = 0, exp_wake = 0;
   logic lvl;
   logic [7:0] rv;

   always #4 clk = ~clk;

   vdrop_mon_top #(.SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .cmp_above(cmp_above),
      .stop_mode(stop_mode), .wdt_ovf(wdt_ovf), .wr_prot_en(wr_prot_en),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_pulse(irq_pulse), .wake_req(wake_req)
   );

   always @(negedge clk) begin
      if (irq_pulse) irq_cnt++;
      if (wake_req)  wake_cnt++;
   end

   function automatic logic [7:0] ctl(input logic [1:0] sel, input logic wdt,
                                      input logic crs, input logic arm, input logic ie);
      return {2'b00, sel, wdt, crs, arm, ie};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic chk_rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, int'(d), int'(exp));
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_lvl(input logic v, input int hold);
      @(negedge clk);
      cmp_above = v;
      wait_cyc(hold);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      por_n = 0; warm_rst = 0; cmp_above = 1; stop_mode = 0; wdt_ovf = 0;
      wr_prot_en = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
      void'($urandom(32'h5A17C3));
      wait_cyc(5);
      por_n = 1;
      wait_cyc(2);

      // reset state (R2, R5, R8)
      chk_rd("R2 mon after reset", 2'd0, 8'h01);
      chk_rd("R5 enable after reset", 2'd1, 8'h00);
      chk_rd("R5 control after reset", 2'd2, 8'h00);
      chk_rd("R8 addr3 reads zero", 2'd3, 8'h00);

      // R4 protection
      wr(2'd1, 8'h01);
      chk_rd("R4 enable write blocked", 2'd1, 8'h00);
      wr(2'd2, 8'h3F);
      chk_rd("R4 control write blocked", 2'd2, 8'h00);
      wr_prot_en = 1;

      // R8 unused bits and read-only register
      wr(2'd0, 8'hFE);
      chk_rd("R8 mon ignores write", 2'd0, 8'h01);
      wr(2'd2, 8'hC0);
      chk_rd("R8 control hi bits", 2'd2, 8'h00);

      // R7 settle: comparator low across enable
      cmp_above = 0;
      wr(2'd1, 8'hFF);
      chk_rd("R8 enable narrow", 2'd1, 8'h01);
      wait_cyc(SETTLE / 2);
      chk_rd("R7 mon ignored during settle", 2'd0, 8'h01);
      wait_cyc(SETTLE + 40);
      chk_rd("R7 mon loaded after settle", 2'd0, 8'h00);
      chk_rd("R7 no crossing on first load", 2'd2, 8'h00);
      lvl = 0;

      // R9/R10/R3 basic crossing
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      drive_lvl(1'b1, 40);
      lvl = 1;
      exp_irq++;
      chk_rd("R9 mon follows high", 2'd0, 8'h01);
      chk_rd("R9 crossing set", 2'd2, ctl(2'd0, 0, 1, 0, 1));
      chk("R10 irq on flag rise", irq_cnt, exp_irq);
      wr(2'd2, ctl(2'd0, 0, 1, 0, 1));
      chk_rd("R3 write 1 keeps crossing", 2'd2, ctl(2'd0, 0, 1, 0, 1));
      drive_lvl(1'b0, 40);
      lvl = 0;
      chk("R10 no irq while flag set", irq_cnt, exp_irq);
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      chk_rd("R3 write 0 clears crossing", 2'd2, ctl(2'd0, 0, 0, 0, 1));

      // R9 short glitch
      drive_lvl(1'b1, 3);
      drive_lvl(1'b0, 40);
      chk_rd("R9 glitch mon", 2'd0, 8'h00);
      chk_rd("R9 glitch no crossing", 2'd2, ctl(2'd0, 0, 0, 0, 1));

      // R1 rate selection with a 40-cycle pulse
      wr(2'd2, ctl(2'd3, 0, 0, 0, 1));
      drive_lvl(1'b1, 40);
      drive_lvl(1'b0, 150);
      chk_rd("R1 div64 rejects 40-cycle pulse", 2'd2, ctl(2'd3, 0, 0, 0, 1));
      chk("R1 div64 no irq", irq_cnt, exp_irq);
      wr(2'd2, ctl(2'd1, 0, 0, 0, 1));
      drive_lvl(1'b1, 40);
      drive_lvl(1'b0, 100);
      exp_irq++;
      chk_rd("R1 div16 accepts 40-cycle pulse", 2'd2, ctl(2'd1, 0, 1, 0, 1));
      chk_rd("R1 div16 mon back low", 2'd0, 8'h00);
      chk("R1 div16 one irq", irq_cnt, exp_irq);
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      drive_lvl(1'b1, 40);
      drive_lvl(1'b0, 60);
      exp_irq++;
      chk_rd("R1 div8 accepts 40-cycle pulse", 2'd2, ctl(2'd0, 0, 1, 0, 1));
      chk("R1 div8 one irq", irq_cnt, exp_irq);

      // R3 watchdog flag
      @(negedge clk); wdt_ovf = 1;
      @(negedge clk); wdt_ovf = 0;
      chk_rd("R3 wdt flag set", 2'd2, ctl(2'd0, 1, 1, 0, 1));
      wr(2'd2, ctl(2'd0, 1, 0, 0, 1));
      chk_rd("R3 wdt write 1 keeps", 2'd2, ctl(2'd0, 1, 0, 0, 1));
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      chk_rd("R3 wdt write 0 clears", 2'd2, ctl(2'd0, 0, 0, 0, 1));

      // random level sequences (R9, R10)
      for (int it = 0; it < 30; it++) begin
         logic nv;
         logic [1:0] sel;
         sel = 2'($urandom_range(0, 1));
         nv  = 1'($urandom_range(0, 1));
         wr(2'd2, ctl(sel, 0, 0, 0, 1));
         if ($urandom_range(0, 2) == 0) drive_lvl(~nv, 2);
         drive_lvl(nv, 100);
         if (nv != lvl) exp_irq++;
         chk_rd("R9 random mon", 2'd0, {7'd0, nv});
         chk_rd("R10 random crossing", 2'd2, ctl(sel, 0, nv != lvl, 0, 1));
         chk("R10 random irq count", irq_cnt, exp_irq);
         lvl = nv;
      end

      // R11 and R6 wake behaviour
      wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      chk("R11 no wake outside stop", wake_cnt, exp_wake);
      stop_mode = 1;
      wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      exp_wake++;
      chk("R11 wake in stop when armed", wake_cnt, exp_wake);
      wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      chk("R6 spent wake stays quiet", wake_cnt, exp_wake);
      wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      chk("R6 rewrite of 1 does not re-arm", wake_cnt, exp_wake);
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      wr(2'd2, ctl(2'd0, 0, 0, 1, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      exp_wake++;
      chk("R6 write 0 then 1 re-arms", wake_cnt, exp_wake);
      wr(2'd2, ctl(2'd0, 0, 0, 0, 1));
      drive_lvl(~lvl, 40); lvl = ~lvl;
      chk("R11 no wake when disarmed", wake_cnt, exp_wake);
      stop_mode = 0;
      exp_irq = irq_cnt;

      // R5 warm reset
      wr(2'd2, ctl(2'd1, 0, 0, 1, 1));
      @(negedge clk); warm_rst = 1;
      @(negedge clk); warm_rst = 0;
      chk_rd("R5 enable kept over warm reset", 2'd1, 8'h01);
      chk_rd("R5 mon kept over warm reset", 2'd0, {7'd0, lvl});
      chk_rd("R5 control cleared by warm reset", 2'd2, 8'h00);
      drive_lvl(~lvl, 40); lvl = ~lvl;
      chk_rd("R10 crossing set with irq disabled", 2'd2, ctl(2'd0, 0, 1, 0, 0));
      chk("R10 no irq while disabled", irq_cnt, exp_irq);

      // R2 disabling forces flags
      if (lvl) begin
         drive_lvl(1'b0, 40);
         lvl = 0;
      end
      chk_rd("R2 mon low before disable", 2'd0, 8'h00);
      wr(2'd1, 8'h00);
      chk_rd("R2 mon forced high when off", 2'd0, 8'h01);
      chk_rd("R2 crossing forced low when off", 2'd2, 8'h00);

      // R5 power-on reset clears enable
      wr(2'd1, 8'h01);
      @(negedge clk); por_n = 0;
      @(negedge clk); por_n = 1;
      chk_rd("R5 enable cleared by power-on", 2'd1, 8'h00);

      summary();
      $finish;
   end
endmodule